// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an eight-input, 10-bit successive-approximation converter. A register port sets which inputs are enabled, how far the bus clock is divided to make the conversion clock, and whether conversions are started one at a time by software or run continuously in hardware. The sequencer selects one analog input on the mux, holds it for a sample step, and then walks a binary search over the DAC code. Each step reads an external comparator, which reports whether the sampled input is at or above the trial code.

Each input has its own result register. That register keeps the last 10-bit value together with a completion flag and a flag for a lost result. Software either issues a start command and waits for one channel's completion flag, or sets the scan bit and reads results as they arrive. Reading a result register acknowledges it.

Top module: `sar_adc_seq`

## Requirements
- R1: Address 0 is the control word. Bits 7:0 are a one-hot input enable mask, bits 15:8 are the divider value, bit 16 is the scan (burst) enable, and bits 26:24 are the start command, where code 1 means start now and code 0 means stop. A read returns the mask, the divider and the scan bit, and returns 0 in every other bit.
- R2: The conversion clock ticks once every (divider + 1) bus cycles. A conversion lasts 11 ticks, so its result and completion flag become visible exactly 11*(divider + 1) bus cycles after the clock edge that accepts the start.
- R3: The first tick period is the sample step: sampleEn is high and dacCode is 0. In each of the following 10 periods, dacCode is the bits kept so far plus the trial bit, working from bit 9 down to bit 0. A trial bit is kept when cmpHigh is 1.
- R4: A control write with start code 1 and scan bit 0 converts the lowest enabled input exactly once, after which the block goes idle. If the mask is zero, the write starts nothing.
- R5: Address 8+n reads input n's result register. The result is in bits 15:6, the completion flag is bit 31, the lost-result flag is bit 30, and all other bits are 0.
- R6: When a conversion of input n completes, input n's completion flag is set and its result field takes the new value.
- R7: If a completion finds that input's completion flag still set, the lost-result flag is set as well.
- R8: A read (regRe) of address 8+n clears both flags of input n from the next cycle onward and keeps the result field. A completion on input n in that same cycle takes precedence.
- R9: While the scan bit is 1 and the mask is nonzero, the block converts the enabled inputs in ascending order, wrapping around and repeating, with no start command.
- R10: A start command that arrives during a conversion is ignored. muxSel does not change from the end of the sample step to the end of the conversion.
- R11: A control write with start code 0 and scan bit 0 during a conversion aborts it, and no result or flag is written.
- R12: After reset, the control word, every result register, muxSel, dacCode and sampleEn are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (acknowledges result flags) |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| cmpHigh | input | 1 | Comparator: sampled input at or above dacCode |
| dacCode | output | 10 | Trial code for the DAC |
| muxSel | output | 3 | Analog input select |
| sampleEn | output | 1 | Sample step in progress |

## Verification
The hardest situations to reach are the ones where the timing of a software action matters against a conversion already in flight: a start command in the middle of a search, an abort, and a completion that lands on a flag nobody has read yet. The bench places each of these with exact cycle counts derived from the divider value. It uses a comparator model that returns a known analog level for each input. For the scan, it records muxSel at every sample step and compares the resulting sequence with the expected ascending, wrapping order. A full sweep of all 1024 codes on one input covers the binary search itself.

// File: rtl/sar_adc_seq_pkg.sv
package sar_adc_seq_pkg;
  localparam int CHAN_W = 3;
  localparam int IDX_W  = 4;

  localparam int SEL_LSB   = 0;
  localparam int DIV_LSB   = 8;
  localparam int BURST_BIT = 16;
  localparam int START_LSB = 24;
  localparam int RES_LSB   = 6;
  localparam int OVR_BIT   = 30;
  localparam int DONE_BIT  = 31;

  localparam logic [2:0] START_NOW = 3'd1;
  localparam logic [2:0] START_OFF = 3'd0;

  typedef struct packed {
    logic              clearSar;
    logic              trialOn;
    logic              resolve;
    logic [IDX_W-1:0]  bitIdx;
    logic              commit;
    logic [CHAN_W-1:0] chan;
    logic              rdClr;
    logic [CHAN_W-1:0] rdChan;
  } seqStrobe_t;
endpackage

// File: rtl/sar_adc_seq_div.sv
module sar_adc_seq_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divVal,
  output logic             tick
);
  logic [DIV_W-1:0] cntQ;

  assign tick = run && (cntQ >= divVal);

  always_ff @(posedge clk) begin
    if (!rstN || !run) cntQ <= '0;
    else if (tick)     cntQ <= '0;
    else               cntQ <= cntQ + 1'b1;
  end
endmodule

// File: rtl/sar_adc_seq_ctl.sv
module sar_adc_seq_ctl
  import sar_adc_seq_pkg::*;
#(
  parameter int CH_N  = 8,
  parameter int RES_W = 10,
  parameter int DIV_W = 8,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [AW-1:0]     regAddr,
  input  logic [31:0]       regWdata,
  input  logic              tick,
  output logic              run,
  output logic [DIV_W-1:0]  divVal,
  output logic [31:0]       ctrlWord,
  output logic [CHAN_W-1:0] muxSel,
  output logic              sampleEn,
  output seqStrobe_t        stb
);
  localparam int CW = CHAN_W;
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(RES_W);
  localparam logic [CW-1:0]    TOP_CH    = CW'(CH_N - 1);

  logic [CH_N-1:0]  selQ;
  logic [DIV_W-1:0] divQ;
  logic             burstQ;
  logic             busyQ, busyD;
  logic [IDX_W-1:0] stepQ, stepD;
  logic [CW-1:0]    chanQ, chanD;

  logic             wrCtl, isData;
  logic [CH_N-1:0]  wSel;
  logic             wBurst;
  logic [2:0]       wCode;
  logic             swStart, burstGo, abort;
  logic             clearSar, commit, resolve;

  function automatic logic [CW-1:0] nextChan(input logic [CH_N-1:0] sel,
                                             input logic [CW-1:0]   cur);
    logic [CW-1:0] r;
    logic          hit;
    r   = cur;
    hit = 1'b0;
    for (int i = 1; i <= CH_N; i++) begin
      int idx;
      idx = (int'(cur) + i) % CH_N;
      if (!hit && sel[idx]) begin
        r   = CW'(idx);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign wrCtl  = regWe && (regAddr == '0);
  assign isData = regAddr[AW-1];
  assign wSel   = regWdata[SEL_LSB +: CH_N];
  assign wBurst = regWdata[BURST_BIT];
  assign wCode  = regWdata[START_LSB +: 3];

  assign swStart = wrCtl && (wCode == START_NOW) && !wBurst && (|wSel);
  assign burstGo = burstQ && (|selQ) && !wrCtl;
  assign abort   = busyQ && wrCtl && (wCode == START_OFF) && !wBurst;

  always_comb begin
    busyD    = busyQ;
    stepD    = stepQ;
    chanD    = chanQ;
    clearSar = 1'b0;
    commit   = 1'b0;
    resolve  = 1'b0;
    if (!busyQ) begin
      if (swStart) begin
        busyD    = 1'b1;
        stepD    = '0;
        chanD    = nextChan(wSel, TOP_CH);
        clearSar = 1'b1;
      end else if (burstGo) begin
        busyD    = 1'b1;
        stepD    = '0;
        chanD    = nextChan(selQ, TOP_CH);
        clearSar = 1'b1;
      end
    end else if (abort) begin
      busyD = 1'b0;
    end else if (tick) begin
      resolve = (stepQ != '0);
      if (stepQ == LAST_STEP) begin
        commit = 1'b1;
        if (burstQ && (|selQ)) begin
          chanD    = nextChan(selQ, chanQ);
          stepD    = '0;
          clearSar = 1'b1;
        end else begin
          busyD = 1'b0;
        end
      end else begin
        stepD = stepQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      divQ   <= '0;
      burstQ <= 1'b0;
      busyQ  <= 1'b0;
      stepQ  <= '0;
      chanQ  <= '0;
    end else begin
      if (wrCtl) begin
        selQ   <= wSel;
        divQ   <= regWdata[DIV_LSB +: DIV_W];
        burstQ <= wBurst;
      end
      busyQ <= busyD;
      stepQ <= stepD;
      chanQ <= chanD;
    end
  end

  assign run      = busyQ;
  assign divVal   = divQ;
  assign muxSel   = chanQ;
  assign sampleEn = busyQ && (stepQ == '0);
  assign ctrlWord = (32'(selQ) << SEL_LSB) | (32'(divQ) << DIV_LSB)
                  | (32'(burstQ) << BURST_BIT);

  always_comb begin
    stb          = '0;
    stb.clearSar = clearSar;
    stb.trialOn  = busyQ && (stepQ != '0);
    stb.resolve  = resolve;
    stb.bitIdx   = LAST_STEP - stepQ;
    stb.commit   = commit;
    stb.chan     = chanQ;
    stb.rdClr    = regRe && isData;
    stb.rdChan   = regAddr[CW-1:0];
  end
endmodule

// File: rtl/sar_adc_seq_dp.sv
module sar_adc_seq_dp
  import sar_adc_seq_pkg::*;
#(
  parameter int CH_N  = 8,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] dacCode,
  output logic [31:0]      dataWord,
  output logic [CH_N-1:0]  doneVec
);
  logic [RES_W-1:0] sarQ, sarNext, trialMask;
  logic [RES_W-1:0] resQ [CH_N];
  logic [CH_N-1:0]  doneQ, ovrQ;

  assign trialMask = stb.trialOn ? (RES_W'(1) << stb.bitIdx) : '0;
  assign dacCode   = sarQ | trialMask;

  always_comb begin
    sarNext = sarQ;
    sarNext[stb.bitIdx] = cmpHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearSar) sarQ <= '0;
    else if (stb.resolve)      sarQ <= sarNext;
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_chan
    logic hitCommit, hitRead;
    assign hitCommit = stb.commit && (int'(stb.chan) == i);
    assign hitRead   = stb.rdClr  && (int'(stb.rdChan) == i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resQ[i]  <= '0;
        doneQ[i] <= 1'b0;
        ovrQ[i]  <= 1'b0;
      end else if (hitCommit) begin
        resQ[i]  <= sarNext;
        doneQ[i] <= 1'b1;
        ovrQ[i]  <= (doneQ[i] && !hitRead) || (ovrQ[i] && !hitRead);
      end else if (hitRead) begin
        doneQ[i] <= 1'b0;
        ovrQ[i]  <= 1'b0;
      end
    end
  end

  assign doneVec = doneQ;
  assign dataWord = (32'(doneQ[stb.rdChan]) << DONE_BIT)
                  | (32'(ovrQ[stb.rdChan]) << OVR_BIT)
                  | (32'(resQ[stb.rdChan]) << RES_LSB);
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_seq_pkg::*;
#(
  parameter int CH_N  = 8,
  parameter int RES_W = 10,
  parameter int DIV_W = 8,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [AW-1:0]     regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic [CHAN_W-1:0] muxSel,
  output logic              sampleEn
);
  seqStrobe_t       stb;
  logic             tick, run;
  logic [DIV_W-1:0] divVal;
  logic [31:0]      ctrlWord, dataWord;
  logic [CH_N-1:0]  doneVec;

  sar_adc_seq_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .run(run), .divVal(divVal), .tick(tick)
  );

  sar_adc_seq_ctl #(.CH_N(CH_N), .RES_W(RES_W), .DIV_W(DIV_W), .AW(AW)) u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .tick(tick), .run(run), .divVal(divVal),
    .ctrlWord(ctrlWord), .muxSel(muxSel), .sampleEn(sampleEn), .stb(stb)
  );

  sar_adc_seq_dp #(.CH_N(CH_N), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .dataWord(dataWord), .doneVec(doneVec)
  );

  always_comb begin
    if (regAddr == '0)       regRdata = ctrlWord;
    else if (regAddr[AW-1])  regRdata = dataWord;
    else                     regRdata = '0;
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk
  import sar_adc_seq_pkg::*;
#(
  parameter int CH_N  = 8,
  parameter int RES_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic [IDX_W-1:0]  step,
  input logic              burst,
  input logic [CHAN_W-1:0] muxSel,
  input logic [RES_W-1:0]  dacCode,
  input seqStrobe_t        stb,
  input logic [CH_N-1:0]   doneVec
);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(RES_W);
  localparam logic [RES_W-1:0] MSB_CODE  = RES_W'(1) << (RES_W - 1);

  // R10
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && step != '0) |-> $stable(muxSel));

  // R3
  msb_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && step == IDX_W'(1)) |-> dacCode == MSB_CODE);

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && step != $past(step)) |->
      ((step == $past(step) + IDX_W'(1)) || (step == '0 && $past(step) == LAST_STEP)));

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> doneVec[$past(stb.chan)]);

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdClr && !(stb.commit && stb.chan == stb.rdChan)) |=> !doneVec[$past(stb.rdChan)]);

  // R4
  sw_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !burst) |=> !busy);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.CH_N(CH_N), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(u_ctl.busyQ), .step(u_ctl.stepQ),
  .burst(u_ctl.burstQ), .muxSel(muxSel), .dacCode(dacCode), .stb(stb),
  .doneVec(doneVec)
);

// File: tb/sim_sar_adc_seq.sv
module sim_sar_adc_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        cmpHigh;
  logic [9:0]  dacCode;
  logic [2:0]  muxSel;
  logic        sampleEn;
  logic [9:0]  vin [8];

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign cmpHigh = (vin[muxSel] >= dacCode);

  sar_adc_seq u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .muxSel(muxSel), .sampleEn(sampleEn)
  );

  // scan order monitor
  bit         logOn = 0;
  bit         prevS = 0;
  int         nLog = 0;
  logic [2:0] scanLog [16];
  always @(negedge clk) begin
    if (logOn && sampleEn && !prevS && nLog < 16) begin
      scanLog[nLog] = muxSel;
      nLog++;
    end
    prevS = sampleEn;
  end

  function automatic logic [31:0] mkCtl(input logic [7:0] sel, input logic [7:0] dv,
                                        input logic bst, input logic [2:0] code);
    return {5'b0, code, 7'b0, bst, dv, sel};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // software conversion, polled until done, then acknowledged
  task automatic convSw(input int ch, input logic [9:0] val, input logic [7:0] dv,
                        input logic [7:0] sel, output int cyc, output logic [31:0] w);
    logic [31:0] p;
    vin[ch] = val;
    wr(4'd0, mkCtl(sel, dv, 1'b0, 3'd1));
    cyc = 0;
    forever begin
      peek(4'(8 + ch), p);
      if (p[31] || cyc > 5000) break;
      @(negedge clk);
      cyc++;
    end
    rd(4'(8 + ch), w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [31:0] w;
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    peek(4'd0, w);  chk(w == 0, "R12 ctrl", w, 0);
    peek(4'd8, w);  chk(w == 0, "R12 data0", w, 0);
    peek(4'd15, w); chk(w == 0, "R12 data7", w, 0);
    chk(muxSel == 0 && dacCode == 0 && sampleEn == 0, "R12 outputs",
        {19'b0, sampleEn, muxSel, dacCode}, 0);

    // R1 readback, start code reads as zero
    wr(4'd0, mkCtl(8'h00, 8'h05, 1'b0, 3'd0));
    peek(4'd0, w); chk(w == 32'h0000_0500, "R1 readback", w, 32'h0000_0500);
    wr(4'd0, mkCtl(8'h00, 8'h07, 1'b0, 3'd1));
    peek(4'd0, w); chk(w == 32'h0000_0700, "R1 start field reads 0", w, 32'h0000_0700);
    waitCyc(20);
    chk(sampleEn == 0, "R4 empty mask starts nothing", {31'b0, sampleEn}, 0);

    // R3 R5 exhaustive sweep on input 3, R2 timing at divider 0
    for (int v = 0; v < 1024; v++) begin
      convSw(3, 10'(v), 8'd0, 8'h08, cyc, w);
      chk(w == (32'h8000_0000 | (32'(v) << 6)), "R3 R5 sweep", w,
          32'h8000_0000 | (32'(v) << 6));
      if (v % 128 == 0) chk(cyc == 11, "R2 div0 latency", cyc, 11);
    end

    // R6 R2 each input at divider 2
    for (int ch = 0; ch < 8; ch++) begin
      logic [9:0] val;
      val = 10'((ch * 131 + 7) % 1024);
      convSw(ch, val, 8'd2, 8'(1 << ch), cyc, w);
      chk(w == (32'h8000_0000 | (32'(val) << 6)), "R6 per-input result", w,
          32'h8000_0000 | (32'(val) << 6));
      chk(cyc == 33, "R2 div2 latency", cyc, 33);
    end
    convSw(1, 10'd77, 8'd3, 8'h02, cyc, w);
    chk(cyc == 44, "R2 div3 latency", cyc, 44);

    // R8 read cleared flags, result kept
    peek(4'd9, w);
    chk(w == (32'(77) << 6), "R8 flags cleared", w, 32'(77) << 6);

    // R3 trial codes during a conversion
    vin[1] = 10'd700;
    wr(4'd0, mkCtl(8'h02, 8'd3, 1'b0, 3'd1));
    chk(sampleEn == 1 && dacCode == 0, "R3 sample step", {21'b0, sampleEn, dacCode}, 32'h400);
    waitCyc(4);
    chk(dacCode == 10'h200, "R3 msb trial", dacCode, 32'h200);
    waitCyc(4);
    chk(dacCode == 10'h300, "R3 second trial after keep", dacCode, 32'h300);
    waitCyc(4);
    chk(dacCode == 10'h280, "R3 third trial after drop", dacCode, 32'h280);
    waitCyc(40);
    rd(4'd9, w);
    chk(w == (32'h8000_0000 | (32'(700) << 6)), "R3 result 700", w,
        32'h8000_0000 | (32'(700) << 6));

    // R4 lowest enabled input chosen, single conversion
    vin[2] = 10'd321; vin[3] = 10'd999;
    wr(4'd0, mkCtl(8'h0C, 8'd1, 1'b0, 3'd1));
    waitCyc(60);
    peek(4'd10, w);
    chk(w == (32'h8000_0000 | (32'(321) << 6)), "R4 lowest input", w,
        32'h8000_0000 | (32'(321) << 6));
    peek(4'd11, w);
    chk(w[31] == 0, "R4 other input untouched", w, 0);
    chk(sampleEn == 0, "R4 idle after one", {31'b0, sampleEn}, 0);
    rd(4'd10, w);

    // R7 lost result
    vin[6] = 10'd100;
    wr(4'd0, mkCtl(8'h40, 8'd1, 1'b0, 3'd1));
    waitCyc(30);
    vin[6] = 10'd200;
    wr(4'd0, mkCtl(8'h40, 8'd1, 1'b0, 3'd1));
    waitCyc(30);
    peek(4'd14, w);
    chk(w == (32'hC000_0000 | (32'(200) << 6)), "R7 overrun", w,
        32'hC000_0000 | (32'(200) << 6));
    rd(4'd14, w);
    peek(4'd14, w);
    chk(w[31:30] == 0, "R8 overrun cleared", w, 32'(200) << 6);

    // R10 start during conversion ignored
    vin[2] = 10'd300; vin[5] = 10'd900;
    wr(4'd0, mkCtl(8'h04, 8'd3, 1'b0, 3'd1));
    waitCyc(10);
    wr(4'd0, mkCtl(8'h20, 8'd3, 1'b0, 3'd1));
    waitCyc(10);
    chk(muxSel == 2, "R10 mux held", muxSel, 2);
    waitCyc(30);
    peek(4'd10, w);
    chk(w == (32'h8000_0000 | (32'(300) << 6)), "R10 first conversion intact", w,
        32'h8000_0000 | (32'(300) << 6));
    peek(4'd13, w);
    chk(w[31] == 0, "R10 second start ignored", w, 0);
    rd(4'd10, w);

    // R11 abort
    vin[4] = 10'd555;
    wr(4'd0, mkCtl(8'h10, 8'd3, 1'b0, 3'd1));
    waitCyc(10);
    wr(4'd0, mkCtl(8'h10, 8'd3, 1'b0, 3'd0));
    waitCyc(60);
    peek(4'd12, w);
    chk(w[31] == 0 && w[15:6] != 10'd555, "R11 abort writes nothing", w, 32'h0);
    chk(sampleEn == 0, "R11 idle", {31'b0, sampleEn}, 0);

    // R9 scan of inputs 0,2,5,7
    vin[0] = 10'd11; vin[2] = 10'd222; vin[5] = 10'd555; vin[7] = 10'd1023;
    logOn = 1;
    wr(4'd0, mkCtl(8'hA5, 8'd0, 1'b1, 3'd0));
    waitCyc(11 * 9 + 4);
    wr(4'd0, mkCtl(8'hA5, 8'd0, 1'b0, 3'd0));
    waitCyc(30);
    logOn = 0;
    chk(nLog >= 8, "R9 scan count", nLog, 8);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] e;
      case (k % 4)
        0: e = 3'd0;
        1: e = 3'd2;
        2: e = 3'd5;
        default: e = 3'd7;
      endcase
      chk(scanLog[k] == e, "R9 scan order", scanLog[k], e);
    end
    for (int k = 0; k < 4; k++) begin
      int ch;
      ch = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 5 : 7;
      peek(4'(8 + ch), w);
      chk(w[31] && w[15:6] == vin[ch], "R9 scan result", w, 32'(vin[ch]) << 6);
    end
    peek(4'd8, w);
    chk(w[30] == 1, "R7 overrun in scan", w, 32'h4000_0000);
    chk(sampleEn == 0, "R9 scan stopped", {31'b0, sampleEn}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule